// File: doc/BRIEF.md
# Delay-Multiply AFSK Bit Demodulator

This block turns a stream of signed audio samples, delivered at a fixed 13.2 kHz rate, into 1200-baud bits for a Bell 202 style packet receiver. Each sample is multiplied by the same signal taken a fixed number of samples earlier. A shift-coefficient first-order low-pass filter smooths the product. The sign of the smoothed value then tells the 1200 Hz tone (mark) from the 2200 Hz tone (space).

A phase counter makes one decision per 11-sample bit period. Sign changes of the smoothed value pull the decision point toward the bit centres, by at most one sample per bit. A carrier gate follows the magnitude of the smoothed value on every sample and holds its flag through short dips. While the carrier is present, every decision is passed on. Framing and line decoding are left to the stage downstream.

Top module: `afsk_dm_demod`

## Requirements
- R1: After reset, `bit_stb`, `bit_val` and `carrier` are all 0.
- R2: A steady 1200 Hz input tone is decoded as `bit_val` = 1 (mark) and a steady 2200 Hz tone as `bit_val` = 0 (space), using a 6-sample delay at 13.2 kHz.
- R3: During a steady tone with no sign change of the smoothed value, `bit_stb` pulses exactly once every 11 input samples.
- R4: Clock recovery moves the decision point by at most one sample per bit, so consecutive strobes while the carrier stays present are 10, 11 or 12 samples apart.
- R5: `carrier` rises only when the smoothed magnitude exceeds `gate_thresh`. With amplitude 1000 and a threshold of 100000, this happens within 20 samples of tone onset, and never on a silent input.
- R6: Once raised, `carrier` stays set through up to 220 consecutive below-threshold samples and clears on the 221st.
- R7: No `bit_stb` is produced while `carrier` is clear, including when `gate_thresh` is above any reachable magnitude.
- R8: While the carrier is present, every decision is emitted even when the smoothed magnitude dips at tone changes. An alternating 4-mark/4-space pattern keeps `carrier` set and yields one strobe per bit, within ±3 over 96 bits.
- R9: `bit_val` changes only in a cycle where `bit_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle pulse per audio sample |
| smp_data | input | SMP_W (12) | Signed two's-complement sample |
| gate_thresh | input | 2*SMP_W (24) | Unsigned carrier threshold on the smoothed magnitude |
| bit_val | output | 1 | Last decided bit, 1 = mark, 0 = space |
| bit_stb | output | 1 | One-cycle pulse when a new bit decision is passed on |
| carrier | output | 1 | Carrier-present flag |

## Verification
A wrong delay tap or a wrong filter sign shows up at once as inverted or scattered bit values within the first few bits of a steady tone. A faulty phase counter shows up as strobe spacing other than 11 within one or two bit periods. An off-by-one or wrong limit in the silence counter moves the carrier drop outside the window of 225 to 300 samples after the tone ends. A gate that lets decisions through without carrier shows up as strobes on a silent or under-threshold input.

// File: rtl/dm_pkg.sv
package dm_pkg;
   // Phase-counter advance per sample chosen by clock recovery
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_ONE  = 2'd1,
      STEP_TWO  = 2'd2
   } phase_step_e;
endpackage

// File: rtl/dm_mixer.sv
module dm_mixer #(
   parameter int SMP_W  = 12,
   parameter int DELAY  = 6,
   parameter int PROD_W = 2 * SMP_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_v,
   input  logic signed [SMP_W-1:0]  in_s,
   output logic                     prod_v,
   output logic signed [PROD_W-1:0] prod
);
   logic signed [SMP_W-1:0] oldest;

   generate
      if (DELAY == 1) begin : g_single
         logic signed [SMP_W-1:0] tap_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    tap_q <= '0;
            else if (in_v) tap_q <= in_s;
         end
         assign oldest = tap_q;
      end else begin : g_chain
         logic signed [SMP_W-1:0] tap_q [DELAY];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DELAY; i++) tap_q[i] <= '0;
            end else if (in_v) begin
               tap_q[0] <= in_s;
               for (int i = 1; i < DELAY; i++) tap_q[i] <= tap_q[i-1];
            end
         end
         assign oldest = tap_q[DELAY-1];
      end
   endgenerate

   logic signed [PROD_W-1:0] a_ext, b_ext;
   assign a_ext = PROD_W'(in_s);
   assign b_ext = PROD_W'(oldest);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_v <= 1'b0;
         prod   <= '0;
      end else begin
         prod_v <= in_v;
         if (in_v) prod <= a_ext * b_ext;
      end
   end
endmodule

// File: rtl/dm_lowpass.sv
module dm_lowpass #(
   parameter int IN_W  = 24,
   parameter int ACC_W = 26,
   parameter int SHIFT = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    x_v,
   input  logic signed [IN_W-1:0]  x,
   output logic                    y_v,
   output logic signed [ACC_W-1:0] y
);
   logic signed [ACC_W-1:0] x_ext, diff, step;
   assign x_ext = ACC_W'(x);
   assign diff  = x_ext - y;
   assign step  = diff >>> SHIFT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_v <= 1'b0;
         y   <= '0;
      end else begin
         y_v <= x_v;
         if (x_v) y <= y + step;
      end
   end
endmodule

// File: rtl/dm_carrier.sv
module dm_carrier #(
   parameter int ACC_W = 26,
   parameter int THR_W = 24,
   parameter int HOLD  = 220
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    y_v,
   input  logic signed [ACC_W-1:0] y,
   input  logic [THR_W-1:0]        thresh,
   output logic                    car_nxt,
   output logic                    carrier
);
   localparam int CW = $clog2(HOLD + 2);
   localparam logic [CW-1:0] SAT = CW'(HOLD + 1);
   localparam logic [CW-1:0] LIM = CW'(HOLD);

   logic [CW-1:0]    sil_q, sil_nxt;
   logic [ACC_W-1:0] mag;
   logic             above;

   assign mag   = y[ACC_W-1] ? ACC_W'(-y) : ACC_W'(y);
   assign above = mag > ACC_W'(thresh);

   always_comb begin
      car_nxt = carrier;
      sil_nxt = sil_q;
      if (y_v) begin
         if (above) begin
            car_nxt = 1'b1;
            sil_nxt = '0;
         end else begin
            if (sil_q != SAT) sil_nxt = sil_q + 1'b1;
            if (sil_nxt > LIM) car_nxt = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carrier <= 1'b0;
         sil_q   <= '0;
      end else begin
         carrier <= car_nxt;
         sil_q   <= sil_nxt;
      end
   end
endmodule

// File: rtl/dm_bitclk.sv
module dm_bitclk
   import dm_pkg::*;
#(
   parameter int SPB = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic y_v,
   input  logic y_neg,
   input  logic car_nxt,
   output logic bit_stb,
   output logic bit_val
);
   localparam int PW = $clog2(SPB + 2);
   localparam logic [PW:0] SPB_L  = (PW+1)'(SPB);
   localparam logic [PW:0] HALF_L = (PW+1)'(SPB / 2);

   logic [PW:0]  ph_q, ph_n, ph_sum;
   logic         prev_neg_q, nudged_q, nudged_n;
   logic         stb_n, val_n;
   phase_step_e  step;

   always_comb begin
      step     = STEP_ONE;
      nudged_n = nudged_q;
      if (y_v && (y_neg != prev_neg_q) && !nudged_q) begin
         if (ph_q < HALF_L) begin
            step     = STEP_TWO;
            nudged_n = 1'b1;
         end else if (ph_q > HALF_L) begin
            step     = STEP_HOLD;
            nudged_n = 1'b1;
         end
      end
      ph_sum = ph_q + (PW+1)'(step);
      ph_n   = ph_q;
      stb_n  = 1'b0;
      val_n  = bit_val;
      if (y_v) begin
         if (ph_sum >= SPB_L) begin
            ph_n     = ph_sum - SPB_L;
            nudged_n = 1'b0;
            if (car_nxt) begin
               stb_n = 1'b1;
               val_n = y_neg;
            end
         end else begin
            ph_n = ph_sum;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q       <= '0;
         prev_neg_q <= 1'b0;
         nudged_q   <= 1'b0;
         bit_stb    <= 1'b0;
         bit_val    <= 1'b0;
      end else begin
         ph_q     <= ph_n;
         nudged_q <= nudged_n;
         bit_stb  <= stb_n;
         bit_val  <= val_n;
         if (y_v) prev_neg_q <= y_neg;
      end
   end
endmodule

// File: rtl/afsk_dm_demod.sv
module afsk_dm_demod #(
   parameter int SMP_W    = 12,
   parameter int DELAY    = 6,
   parameter int SPB      = 11,
   parameter int ALPHA_SH = 3,
   parameter int HOLD     = 220,
   parameter int GUARD    = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid,
   input  logic [SMP_W-1:0]       smp_data,
   input  logic [2*SMP_W-1:0]     gate_thresh,
   output logic                   bit_val,
   output logic                   bit_stb,
   output logic                   carrier
);
   localparam int PROD_W = 2 * SMP_W;
   localparam int ACC_W  = PROD_W + GUARD;
   localparam int THR_W  = PROD_W;

   generate
      if (SMP_W < 2)               begin : g_bad_w     $error("SMP_W too small");  end
      if (DELAY < 1)               begin : g_bad_d     $error("DELAY must be >= 1"); end
      if (SPB < 4)                 begin : g_bad_spb   $error("SPB must be >= 4"); end
      if (ALPHA_SH < 1 || ALPHA_SH >= ACC_W) begin : g_bad_a $error("ALPHA_SH out of range"); end
      if (HOLD < 1)                begin : g_bad_h     $error("HOLD must be >= 1"); end
      if (GUARD < 1)               begin : g_bad_g     $error("GUARD must be >= 1"); end
   endgenerate

   logic                    prod_v, y_v, car_nxt;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  y;
   logic signed [SMP_W-1:0]  s_in;

   assign s_in = smp_data;

   dm_mixer #(.SMP_W(SMP_W), .DELAY(DELAY), .PROD_W(PROD_W)) u_mix (
      .clk(clk), .rst_n(rst_n), .in_v(smp_valid), .in_s(s_in),
      .prod_v(prod_v), .prod(prod));

   dm_lowpass #(.IN_W(PROD_W), .ACC_W(ACC_W), .SHIFT(ALPHA_SH)) u_lpf (
      .clk(clk), .rst_n(rst_n), .x_v(prod_v), .x(prod),
      .y_v(y_v), .y(y));

   dm_carrier #(.ACC_W(ACC_W), .THR_W(THR_W), .HOLD(HOLD)) u_car (
      .clk(clk), .rst_n(rst_n), .y_v(y_v), .y(y), .thresh(gate_thresh),
      .car_nxt(car_nxt), .carrier(carrier));

   dm_bitclk #(.SPB(SPB)) u_clk (
      .clk(clk), .rst_n(rst_n), .y_v(y_v), .y_neg(y[ACC_W-1]),
      .car_nxt(car_nxt), .bit_stb(bit_stb), .bit_val(bit_val));
endmodule

// File: rtl/dm_demod_chk.sv
module dm_demod_chk #(
   parameter int SPB = 11
) (
   input logic clk,
   input logic rst_n,
   input logic smp_valid,
   input logic bit_stb,
   input logic bit_val,
   input logic carrier
);
   localparam logic [7:0] GAP_LO = 8'(SPB - 1);
   localparam logic [7:0] GAP_HI = 8'(SPB + 1);

   logic [2:0] vd;
   logic [7:0] gap_q;
   logic       armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vd    <= '0;
         gap_q <= '0;
         armed <= 1'b0;
      end else begin
         vd <= {vd[1:0], smp_valid};
         if (bit_stb) begin
            gap_q <= '0;
            armed <= 1'b1;
         end else if (vd[2] && gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
         end
         if (!carrier) armed <= 1'b0;
      end
   end

   // R7: decisions pass only with carrier present
   a_r7_stb_needs_carrier: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> carrier);

   // R9: decided value only moves with a strobe
   a_r9_val_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |-> (bit_val == $past(bit_val)));

   // R3: a strobe is always caused by a sample three stages back
   a_r3_stb_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> vd[2]);

   // R4: strobe spacing within one sample of nominal
   a_r4_gap_window: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && armed) |-> ((gap_q + 8'd1) >= GAP_LO && (gap_q + 8'd1) <= GAP_HI));

   // R5: carrier rises only on a processed sample
   a_r5_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier) |-> vd[2]);

   // R6: carrier falls only on a processed sample
   a_r6_fall_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(carrier) |-> vd[2]);
endmodule

bind afsk_dm_demod dm_demod_chk #(.SPB(SPB)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
   .bit_stb(bit_stb), .bit_val(bit_val), .carrier(carrier));

// File: tb/sim_afsk_dm_demod.sv
`timescale 1ns/1ps
module sim_afsk_dm_demod;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic [23:0] gate_thresh = 24'd100000;
   logic        bit_val, bit_stb, carrier;

   int checks = 0, errors = 0;
   int n_smp = 0, stb_cnt = 0, ones = 0, zeros = 0;
   int gmin = 1000, gmax = 0, last_idx = -1, car_low = 0, bad_val = 0;
   logic prev_val = 1'b0;
   real ph = 0.0;
   localparam real TWO_PI = 6.283185307179586;
   localparam real AMP = 1000.0;

   always #10 clk = ~clk;

   afsk_dm_demod u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .gate_thresh(gate_thresh), .bit_val(bit_val), .bit_stb(bit_stb),
      .carrier(carrier));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (bit_stb) begin
         stb_cnt++;
         if (bit_val) ones++; else zeros++;
         if (last_idx >= 0) begin
            if (n_smp - last_idx < gmin) gmin = n_smp - last_idx;
            if (n_smp - last_idx > gmax) gmax = n_smp - last_idx;
         end
         last_idx = n_smp;
      end else if (bit_val != prev_val) begin
         bad_val++;
      end
      prev_val = bit_val;
      if (!carrier) car_low++;
   endtask

   task automatic clear_stats();
      stb_cnt = 0; ones = 0; zeros = 0;
      gmin = 1000; gmax = 0; last_idx = -1; car_low = 0;
   endtask

   task automatic send(input int s);
      smp_valid = 1'b1;
      smp_data  = s[11:0];
      n_smp++;
      tick();
      smp_valid = 1'b0;
      repeat (3) tick();
   endtask

   task automatic tone(input real freq, input int n);
      for (int i = 0; i < n; i++) begin
         send($rtoi(AMP * $sin(ph)));
         ph = ph + TWO_PI * freq / 13200.0;
         if (ph > TWO_PI) ph = ph - TWO_PI;
      end
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) send(0);
   endtask

   task automatic t_reset();
      check(bit_stb == 1'b0, "R1 bit_stb after reset", int'(bit_stb), 0);
      check(bit_val == 1'b0, "R1 bit_val after reset", int'(bit_val), 0);
      check(carrier == 1'b0, "R1 carrier after reset", int'(carrier), 0);
   endtask

   task automatic t_silent_input();
      clear_stats();
      quiet(300);
      check(carrier == 1'b0, "R5 no carrier on silence", int'(carrier), 0);
      check(stb_cnt == 0, "R7 no strobes on silence", stb_cnt, 0);
   endtask

   task automatic t_mark();
      tone(1200.0, 20);
      check(carrier == 1'b1, "R5 carrier within 20 samples", int'(carrier), 1);
      tone(1200.0, 35);
      clear_stats();
      tone(1200.0, 385);
      check(ones == 35 && zeros == 0, "R2 mark decoded as 1", ones, 35);
      check(stb_cnt == 35, "R3 strobe count on mark", stb_cnt, 35);
      check(gmin == 11 && gmax == 11, "R3 spacing on mark", gmax, 11);
   endtask

   task automatic t_space();
      tone(2200.0, 55);
      clear_stats();
      tone(2200.0, 385);
      check(zeros == 35 && ones == 0, "R2 space decoded as 0", zeros, 35);
      check(gmin == 11 && gmax == 11, "R3 spacing on space", gmin, 11);
   endtask

   task automatic t_mixed();
      clear_stats();
      for (int k = 0; k < 12; k++) begin
         tone(1200.0, 44);
         tone(2200.0, 44);
      end
      check(car_low == 0, "R8 carrier held through transitions", car_low, 0);
      check(stb_cnt >= 93 && stb_cnt <= 99, "R8 one strobe per bit", stb_cnt, 96);
      check(gmin >= 10 && gmax <= 12, "R4 spacing within one sample", gmax, 12);
      check(ones >= 36 && zeros >= 36, "R8 both tones decided", ones, 48);
   endtask

   task automatic t_holdoff();
      quiet(225);
      check(carrier == 1'b1, "R6 carrier held after 225 quiet samples", int'(carrier), 1);
      quiet(75);
      check(carrier == 1'b0, "R6 carrier dropped by 300 quiet samples", int'(carrier), 0);
      clear_stats();
      quiet(200);
      check(stb_cnt == 0, "R7 no strobes after carrier loss", stb_cnt, 0);
   endtask

   task automatic t_high_thresh();
      gate_thresh = 24'hFFFFFF;
      clear_stats();
      tone(1200.0, 330);
      check(carrier == 1'b0, "R5 threshold above magnitude", int'(carrier), 0);
      check(stb_cnt == 0, "R7 no strobes without carrier", stb_cnt, 0);
      gate_thresh = 24'd100000;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_silent_input();
      t_mark();
      t_space();
      t_mixed();
      t_holdoff();
      t_high_thresh();
      check(bad_val == 0, "R9 bit_val moves only with strobe", bad_val, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
   end
endmodule